// File: doc/BRIEF.md
# DMA Channel Control and Status Register Unit

This block is the register face of a single DMA channel. A host reaches four 32-bit words through a plain register port with word-wide writes and a combinational read. Word 0 is the control/status word. It carries the interrupt pending and enable flags, a self-clearing drain command, a peripheral reset command, the transfer direction, the DMA enable and an address-loaded flag. Word 1 holds the transfer address. Words 2 and 3 are general storage.

Three things act on the unit from the peripheral side. A level interrupt input sets and clears the pending flag. A host interrupt output is raised when that flag is pending and enabled. A transfer-complete strobe carries a byte count, and that count is added to the address word. The unit also drives a DMA-enable level and a one-cycle reset pulse back to the peripheral. The register port and the transfer strobe are single-cycle events with no back-pressure. The unit accepts one of each on every cycle.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, word 0 reads 0xA0000000, words 1 to 3 read 0, and host_irq, dma_en and periph_rst are all 0.
- R2: Only reg_addr[3:2] selects the word (0 control/status, 1 address, 2 and 3 storage). Higher offset bits are ignored, so offset 0x14 reaches word 1 and offset 0x38 reaches word 2.
- R3: In word 0, bits 31:25 and 2:0 are read-only and keep their value on a write. Bits 31 and 29 (the version value 0xA0000000) always read as 1.
- R4: If bit 7 of a word-0 write is clear, a set bit 6 (drain) is stored as 0. A word-0 write of exactly 0 is stored with only bit 6 set among the writable bits.
- R5: A word-0 write with bit 7 set drives periph_rst high for exactly the one cycle after the write. Bit 7 is stored as written, and bit 6 is stored unchanged.
- R6: dma_en rises in the cycle after a word-0 write that sets bit 9 while bit 9 was clear. It falls after a write that clears bit 9 while bit 9 was set.
- R7: A rising edge on periph_irq sets word-0 bit 0 (pending) one cycle later. A falling edge clears it one cycle later.
- R8: host_irq is a registered level equal to pending (bit 0) AND enable (bit 4). It follows a periph_irq edge or a word-0 write with one cycle of latency.
- R9: A write to word 1 stores the full 32-bit value and sets word-0 bit 26 (loaded). Bit 26 then stays set through later word-0 writes.
- R10: Each cycle with xfer_done high adds xfer_bytes to word 1. A word-1 write in the same cycle takes precedence over the add.
- R11: Writes to words 2 and 3 store all 32 bits, and reads return them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W (8) | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| periph_irq | input | 1 | Interrupt level from the peripheral |
| xfer_done | input | 1 | Transfer-complete strobe |
| xfer_bytes | input | LEN_W (16) | Byte count of the completed transfer |
| host_irq | output | 1 | Interrupt level to the host |
| dma_en | output | 1 | DMA enable level to the peripheral |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |

## Verification
A wrong pending or enable flag shows up on host_irq in the cycle right after the edge or write that caused it. It also shows up on a read-back of word 0, where bits 0 and 4 disagree with the history of periph_irq. A corrupted read-only field, or a drain bit that does not clear, shows up on the next read of word 0, because the version bits and the loaded bit are fully predictable. An address that is not advanced or not overwritten shows up on the first read of word 1 after the strobe.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int SEL_W     = $clog2(NUM_WORDS);
  localparam int SEL_LSB   = 2;

  localparam logic [DATA_W-1:0] CSR_RO_MASK = 32'hFE00_0007;
  localparam logic [DATA_W-1:0] CSR_VERSION = 32'hA000_0000;

  localparam int B_PEND   = 0;
  localparam int B_IEN    = 4;
  localparam int B_DRAIN  = 6;
  localparam int B_PRST   = 7;
  localparam int B_TOMEM  = 8;
  localparam int B_DMAEN  = 9;
  localparam int B_LOADED = 26;

  typedef enum logic [SEL_W-1:0] {
    W_CTRL = 2'd0,
    W_ADDR = 2'd1,
    W_AUX0 = 2'd2,
    W_AUX1 = 2'd3
  } word_sel_e;
endpackage

// File: rtl/dma_irq_gate.sv
module dma_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic periph_irq,
  input  logic csr_we,
  input  logic wr_ien,
  input  logic pend_q,
  input  logic ien_q,
  output logic irq_rise,
  output logic irq_fall,
  output logic host_irq
);
  logic prev_q;
  logic pend_nx;
  logic ien_nx;

  assign irq_rise = periph_irq & ~prev_q;
  assign irq_fall = ~periph_irq & prev_q;
  assign pend_nx  = irq_rise ? 1'b1 : (irq_fall ? 1'b0 : pend_q);
  assign ien_nx   = csr_we ? wr_ien : ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      prev_q <= periph_irq;
      if (csr_we) begin
        if (wr_ien) begin
          if (pend_nx) host_irq <= 1'b1;
        end else if (pend_q || ien_q) begin
          host_irq <= 1'b0;
        end
      end
      if (irq_rise && ien_nx) host_irq <= 1'b1;
      if (irq_fall && pend_q && ien_nx) host_irq <= 1'b0;
    end
  end

  // R8: interrupt output tracks pending AND enable held in the CSR unit
  a_r8_irq_is_gated_pending: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == (pend_q & ien_q));
  // R7: a rising input edge always leaves pending set
  a_r7_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> pend_q);
endmodule

// File: rtl/dma_csr_unit.sv
module dma_csr_unit
  import dma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              addr_loaded,
  input  logic              irq_rise,
  input  logic              irq_fall,
  output logic [DATA_W-1:0] csr_q,
  output logic              dma_en_o,
  output logic              periph_rst_o
);
  logic [DATA_W-1:0] wr_val;
  logic [DATA_W-1:0] csr_nx;
  logic              rst_req;

  always_comb begin
    wr_val  = wdata;
    rst_req = 1'b0;
    if (wdata[B_PRST]) begin
      rst_req = 1'b1;
    end else if (wdata[B_DRAIN]) begin
      wr_val[B_DRAIN] = 1'b0;
    end else if (wdata == '0) begin
      wr_val[B_DRAIN] = 1'b1;
    end
  end

  always_comb begin
    csr_nx = csr_q;
    if (csr_we) csr_nx = (csr_q & CSR_RO_MASK) | (wr_val & ~CSR_RO_MASK) | CSR_VERSION;
    if (addr_loaded) csr_nx[B_LOADED] = 1'b1;
    if (irq_rise) csr_nx[B_PEND] = 1'b1;
    else if (irq_fall) csr_nx[B_PEND] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q        <= CSR_VERSION;
      dma_en_o     <= 1'b0;
      periph_rst_o <= 1'b0;
    end else begin
      csr_q        <= csr_nx;
      periph_rst_o <= csr_we && rst_req;
      if (csr_we && wr_val[B_DMAEN] && !csr_q[B_DMAEN]) dma_en_o <= 1'b1;
      else if (csr_we && !wr_val[B_DMAEN] && csr_q[B_DMAEN]) dma_en_o <= 1'b0;
    end
  end

  // R3: read-only upper field survives a CSR write
  a_r3_ro_upper_held: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !addr_loaded) |=> (csr_q[31:25] == $past(csr_q[31:25])));
  // R5: reset pulse only follows a write carrying the reset command
  a_r5_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_rst_o) |-> $past(csr_we && wdata[B_PRST]));
  // R6: enable level agrees with stored enable bit
  a_r6_en_matches_bit: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en_o == csr_q[B_DMAEN]);
  // R9: address write marks the address as loaded
  a_r9_loaded_set: assert property (@(posedge clk) disable iff (!rst_n)
    addr_loaded |=> csr_q[B_LOADED]);
endmodule

// File: rtl/dma_word_bank.sv
module dma_word_bank
  import dma_regs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_bytes,
  output logic [DATA_W-1:0] words [NUM_WORDS]
);
  logic addr_we;
  assign addr_we  = we && (sel == W_ADDR);
  assign words[0] = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) words[W_ADDR] <= '0;
    else if (addr_we) words[W_ADDR] <= wdata;
    else if (xfer_done) words[W_ADDR] <= words[W_ADDR] + DATA_W'(xfer_bytes);
  end

  for (genvar g = 2; g < NUM_WORDS; g++) begin : g_aux
    always_ff @(posedge clk) begin
      if (!rst_n) words[g] <= '0;
      else if (we && (sel == SEL_W'(g))) words[g] <= wdata;
    end
  end

  // R10: strobe without a competing write advances the address by the count
  a_r10_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !addr_we) |=> (words[W_ADDR] == $past(words[W_ADDR]) + DATA_W'($past(xfer_bytes))));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              periph_irq,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_bytes,
  output logic              host_irq,
  output logic              dma_en,
  output logic              periph_rst
);
  logic [SEL_W-1:0]  sel;
  logic              csr_we;
  logic              addr_we;
  logic              irq_rise;
  logic              irq_fall;
  logic [DATA_W-1:0] csr_q;
  logic [DATA_W-1:0] words [NUM_WORDS];

  assign sel     = reg_addr[SEL_LSB +: SEL_W];
  assign csr_we  = reg_wr && (sel == W_CTRL);
  assign addr_we = reg_wr && (sel == W_ADDR);

  dma_irq_gate u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_irq (periph_irq),
    .csr_we     (csr_we),
    .wr_ien     (reg_wdata[B_IEN]),
    .pend_q     (csr_q[B_PEND]),
    .ien_q      (csr_q[B_IEN]),
    .irq_rise   (irq_rise),
    .irq_fall   (irq_fall),
    .host_irq   (host_irq)
  );

  dma_csr_unit u_csr (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_we       (csr_we),
    .wdata        (reg_wdata),
    .addr_loaded  (addr_we),
    .irq_rise     (irq_rise),
    .irq_fall     (irq_fall),
    .csr_q        (csr_q),
    .dma_en_o     (dma_en),
    .periph_rst_o (periph_rst)
  );

  dma_word_bank #(.LEN_W(LEN_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_wr),
    .sel        (sel),
    .wdata      (reg_wdata),
    .xfer_done  (xfer_done),
    .xfer_bytes (xfer_bytes),
    .words      (words)
  );

  assign reg_rdata = (sel == W_CTRL) ? csr_q : words[sel];

  // R1: version bits present whenever out of reset
  a_r1_version_present: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (csr_q[31] && csr_q[29]));
endmodule

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        periph_irq = 1'b0;
  logic        xfer_done = 1'b0;
  logic [15:0] xfer_bytes = '0;
  logic        host_irq, dma_en, periph_rst;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dma_chan_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_irq(periph_irq),
    .xfer_done(xfer_done), .xfer_bytes(xfer_bytes), .host_irq(host_irq),
    .dma_en(dma_en), .periph_rst(periph_rst)
  );

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{8'h00, 32'h0000_0210, 8'h00, 32'hA000_0210},
    '{8'h00, 32'hFFFF_FFFF, 8'h00, 32'hA1FF_FFF8},
    '{8'h00, 32'h0000_0040, 8'h00, 32'hA000_0000},
    '{8'h00, 32'h0000_0000, 8'h00, 32'hA000_0040},
    '{8'h00, 32'h5A00_0003, 8'h00, 32'hA000_0000},
    '{8'h04, 32'h1234_5678, 8'h00, 32'hA400_0000},
    '{8'h04, 32'hDEAD_BEEF, 8'h04, 32'hDEAD_BEEF},
    '{8'h08, 32'hCAFE_F00D, 8'h08, 32'hCAFE_F00D},
    '{8'h0C, 32'h0BAD_C0DE, 8'h0C, 32'h0BAD_C0DE},
    '{8'h14, 32'h0000_1000, 8'h04, 32'h0000_1000},
    '{8'h38, 32'h55AA_55AA, 8'h08, 32'h55AA_55AA},
    '{8'h00, 32'h0000_0000, 8'h00, 32'hA400_0040}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #2; d = reg_rdata;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] r;
    do_reset();
    // R1 reset state
    rd(8'h00, r); check("R1 word0", r, 32'hA000_0000);
    for (int i = 1; i < 4; i++) begin
      rd(8'(i * 4), r); check("R1 word", r, 32'h0);
    end
    check("R1 outputs", {29'd0, host_irq, dma_en, periph_rst}, 32'h0);

    // vector table: R2 R3 R4 R9 R11
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, r);
      check($sformatf("R2/R3/R4/R9/R11 vec%0d", i), r, VEC[i].ex);
    end

    // R5 reset pulse
    do_reset();
    wr(8'h00, 32'h0000_00C0);
    check("R5 pulse high", {31'd0, periph_rst}, 32'h1);
    rd(8'h00, r); check("R5 stored", r, 32'hA000_00C0);
    @(negedge clk);
    check("R5 pulse one cycle", {31'd0, periph_rst}, 32'h0);

    // R6 enable level
    wr(8'h00, 32'h0000_0200);
    check("R6 en rise", {31'd0, dma_en}, 32'h1);
    wr(8'h00, 32'h0000_0000);
    check("R6 en fall", {31'd0, dma_en}, 32'h0);

    // R7 R8 interrupt path
    wr(8'h00, 32'h0000_0010);
    check("R8 idle irq", {31'd0, host_irq}, 32'h0);
    @(negedge clk); periph_irq = 1'b1;
    @(negedge clk);
    check("R8 irq raise", {31'd0, host_irq}, 32'h1);
    rd(8'h00, r); check("R7 pending set", r, 32'hA000_0011);
    wr(8'h00, 32'h0000_0000);
    check("R8 irq masked", {31'd0, host_irq}, 32'h0);
    rd(8'h00, r); check("R7 pending kept", r, 32'hA000_0041);
    wr(8'h00, 32'h0000_0010);
    check("R8 irq re-enable", {31'd0, host_irq}, 32'h1);
    @(negedge clk); periph_irq = 1'b0;
    @(negedge clk);
    check("R8 irq drop", {31'd0, host_irq}, 32'h0);
    rd(8'h00, r); check("R7 pending cleared", r, 32'hA000_0010);
    wr(8'h00, 32'h0000_0100);
    @(negedge clk); periph_irq = 1'b1;
    @(negedge clk);
    check("R8 no irq when disabled", {31'd0, host_irq}, 32'h0);
    rd(8'h00, r); check("R7 pending while disabled", r, 32'hA000_0101);
    periph_irq = 1'b0;
    @(negedge clk);

    // R10 address advance
    wr(8'h04, 32'h0000_0100);
    @(negedge clk); xfer_done = 1'b1; xfer_bytes = 16'h0020;
    @(negedge clk); xfer_done = 1'b0;
    rd(8'h04, r); check("R10 single add", r, 32'h0000_0120);
    @(negedge clk); xfer_done = 1'b1; xfer_bytes = 16'h0004;
    @(negedge clk); xfer_bytes = 16'h0008;
    @(negedge clk); xfer_done = 1'b0;
    rd(8'h04, r); check("R10 back to back", r, 32'h0000_012C);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h0000_4000;
    xfer_done = 1'b1; xfer_bytes = 16'h0010;
    @(negedge clk); reg_wr = 1'b0; xfer_done = 1'b0;
    rd(8'h04, r); check("R10 write wins", r, 32'h0000_4000);
    rd(8'h00, r); check("R9 loaded", r, 32'hA400_0100);

    report();
  end
endmodule